// File: doc/BRIEF.md
# Ethernet Receive Frame Validity Checker

This block watches the receive data stream of one Ethernet port after the preamble and start delimiter have been removed. While beats arrive it runs the Ethernet CRC-32 and counts whole bytes. When the end-of-frame pulse comes, it decides whether the frame may be kept. One cycle later it raises either a keep strobe or a discard strobe. Both come with a reason code and a set of error flags, so the buffer writer can commit the stored frame or throw it away.

The data path is 4 bits wide (nibbles, low nibble of each byte first) or 8 bits wide, chosen by a parameter. Two straps set how checking is done: one raises the length ceiling for VLAN-tagged frames, the other turns off the discard on a bad CRC. Both straps are captured once after reset and held until the next reset. A leftover half byte at the end of the frame can come from the nibble count or from a separate dribble input. Such a frame is dropped as misaligned only when the CRC over its whole bytes also fails.

Top module: `frm_rx_check`

## Requirements
- R1: A frame of fewer than 64 whole bytes (FCS included) is dropped with reason 1. A frame of exactly 64 bytes passes the length check.
- R2: With the VLAN strap at 0, a frame longer than 1518 bytes is dropped with reason 2. A frame of exactly 1518 bytes passes the length check.
- R3: With the VLAN strap at 1, the ceiling is 1522 bytes: 1522 passes and 1523 is dropped with reason 2.
- R4: A frame that ends on a byte boundary and whose CRC residue is wrong is dropped with reason 4. When the CRC-disable strap is 1, that frame is kept instead. The CRC is CRC-32 (polynomial 0x04C11DB7, bits taken LSB first, initial value all ones), and the residue over data plus FCS must equal 0xC704DD7B.
- R5: A frame that ends with an odd half byte has the CRC judged over its whole bytes only. The odd half byte comes from an odd nibble count, or from dribble_i high in the end-of-frame cycle. If that CRC is bad, the frame is dropped with reason 3 whatever the CRC-disable strap says. If it is good, the frame is kept.
- R6: Both straps are captured at the first clock edge after reset is released and ignored after that. Until then they read as 0.
- R7: The byte count saturates at 2047, so a frame of 2148 bytes is still dropped as too long and does not wrap to a legal length.
- R8: Each end-of-frame pulse gives exactly one strobe, good_o or drop_o, in the cycle after the pulse. Any beat presented in the end-of-frame cycle is ignored.
- R9: The reason code is 0 on good_o and follows the priority runt (1) > long (2) > alignment (3) > CRC (4) on drop_o. err_o shows every detected fault: bit 0 runt, bit 1 long, bit 2 alignment, bit 3 CRC.
- R10: In reset, and in every cycle without a strobe, good_o, drop_o, reason_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Data beat present |
| data_i | input | DW | Data beat, LSB first on the wire |
| eof_i | input | 1 | End of frame, one cycle after the last beat |
| dribble_i | input | 1 | Extra half byte seen at end of frame |
| vlan_strap_i | input | 1 | Raise length ceiling to 1522 |
| crc_off_strap_i | input | 1 | Keep frames with a bad CRC |
| good_o | output | 1 | Frame accepted strobe |
| drop_o | output | 1 | Frame discarded strobe |
| reason_o | output | 3 | Verdict reason code |
| err_o | output | 4 | Detected fault flags |

## Verification
The hardest case to reach is a frame whose byte counter passes its saturation point. Without saturation the count wraps back to a legal length and a long frame would look valid. The bench sends a 2148-byte frame with a correct FCS, so a wrapped counter would show up as a keep strobe. Alignment faults are reached two ways: by adding a trailing nibble to frames whose payload has been corrupted, and by raising the dribble input on frames that end cleanly. This covers both sources of the odd half byte against both CRC outcomes.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
  typedef enum logic [2:0] {
    RSN_OK    = 3'd0,
    RSN_RUNT  = 3'd1,
    RSN_LONG  = 3'd2,
    RSN_ALIGN = 3'd3,
    RSN_CRC   = 3'd4
  } reason_e;

  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hC704DD7B;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
    return (c >> 1) ^ ((c[0] ^ d) ? CRC_POLY_REF : 32'h0);
  endfunction
endpackage

// File: rtl/frm_strap.sv
`timescale 1ns/1ps
module frm_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vlan_i,
  input  logic crc_off_i,
  output logic vlan_o,
  output logic crc_off_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      vlan_o    <= 1'b0;
      crc_off_o <= 1'b0;
    end else if (!armed_q) begin
      armed_q   <= 1'b1;
      vlan_o    <= vlan_i;
      crc_off_o <= crc_off_i;
    end
  end
endmodule

// File: rtl/frm_len.sv
`timescale 1ns/1ps
module frm_len #(
  parameter int DW      = 4,
  parameter int LEN_MAX = 2047,
  localparam int LEN_W  = $clog2(LEN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             beat_i,
  output logic             half_o,
  output logic             whole_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(LEN_MAX);

  generate
    if (DW == 4) begin : g_nib
      logic half_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     half_q <= 1'b0;
        else if (clr_i)  half_q <= 1'b0;
        else if (beat_i) half_q <= ~half_q;
      end
      assign half_o  = half_q;
      assign whole_o = beat_i & half_q;
    end else begin : g_byte
      assign half_o  = 1'b0;
      assign whole_o = beat_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      len_o <= '0;
    else if (clr_i)                   len_o <= '0;
    else if (whole_o && len_o != SAT) len_o <= len_o + 1'b1;
  end
endmodule

// File: rtl/frm_crc.sv
`timescale 1ns/1ps
module frm_crc
  import frm_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          beat_i,
  input  logic          whole_i,
  input  logic [DW-1:0] data_i,
  output logic          crc_ok_o
);
  localparam logic [31:0] RES_REF = rev32(CRC_RESIDUE);

  logic [31:0] run_q, whole_q, nxt;

  always_comb begin
    nxt = run_q;
    for (int i = 0; i < DW; i++) nxt = crc_bit(nxt, data_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '1;
      whole_q <= '1;
    end else if (clr_i) begin
      run_q   <= '1;
      whole_q <= '1;
    end else begin
      if (beat_i)  run_q   <= nxt;
      if (whole_i) whole_q <= nxt;  // snapshot at byte boundaries only
    end
  end

  assign crc_ok_o = (whole_q == RES_REF);
endmodule

// File: rtl/frm_verdict.sv
`timescale 1ns/1ps
module frm_verdict
  import frm_pkg::*;
#(
  parameter int LEN_MIN = 64,
  parameter int LEN_STD = 1518,
  parameter int LEN_TAG = 1522,
  parameter int LEN_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             half_i,
  input  logic             dribble_i,
  input  logic             crc_ok_i,
  input  logic             vlan_i,
  input  logic             crc_off_i,
  output logic             good_o,
  output logic             drop_o,
  output logic [2:0]       reason_o,
  output logic [3:0]       err_o
);
  logic [LEN_W-1:0] ceil;
  logic runt, lng, odd, bad, aln, crc_e;
  reason_e rsn;

  always_comb begin
    ceil  = vlan_i ? LEN_W'(LEN_TAG) : LEN_W'(LEN_STD);
    runt  = len_i < LEN_W'(LEN_MIN);
    lng   = len_i > ceil;
    odd   = half_i | dribble_i;
    bad   = ~crc_ok_i;
    aln   = odd & bad;
    crc_e = ~odd & bad & ~crc_off_i;
    if (runt)       rsn = RSN_RUNT;
    else if (lng)   rsn = RSN_LONG;
    else if (aln)   rsn = RSN_ALIGN;
    else if (crc_e) rsn = RSN_CRC;
    else            rsn = RSN_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_o   <= 1'b0;
      drop_o   <= 1'b0;
      reason_o <= '0;
      err_o    <= '0;
    end else if (eof_i) begin
      good_o   <= (rsn == RSN_OK);
      drop_o   <= (rsn != RSN_OK);
      reason_o <= rsn;
      err_o    <= {crc_e, aln, lng, runt};
    end else begin
      good_o   <= 1'b0;
      drop_o   <= 1'b0;
      reason_o <= '0;
      err_o    <= '0;
    end
  end
endmodule

// File: rtl/frm_rx_check.sv
`timescale 1ns/1ps
module frm_rx_check #(
  parameter int DW      = 4,
  parameter int LEN_MIN = 64,
  parameter int LEN_STD = 1518,
  parameter int LEN_TAG = 1522,
  parameter int LEN_MAX = 2047
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          eof_i,
  input  logic          dribble_i,
  input  logic          vlan_strap_i,
  input  logic          crc_off_strap_i,
  output logic          good_o,
  output logic          drop_o,
  output logic [2:0]    reason_o,
  output logic [3:0]    err_o
);
  localparam int LEN_W = $clog2(LEN_MAX + 1);

  logic beat, half, whole, crc_ok, vlan_q, crc_off_q;
  logic [LEN_W-1:0] len;

  assign beat = valid_i & ~eof_i;  // eof cycle carries no data

  frm_strap u_strap (
    .clk_i, .rst_ni,
    .vlan_i(vlan_strap_i), .crc_off_i(crc_off_strap_i),
    .vlan_o(vlan_q), .crc_off_o(crc_off_q)
  );

  frm_len #(.DW(DW), .LEN_MAX(LEN_MAX)) u_len (
    .clk_i, .rst_ni, .clr_i(eof_i), .beat_i(beat),
    .half_o(half), .whole_o(whole), .len_o(len)
  );

  frm_crc #(.DW(DW)) u_crc (
    .clk_i, .rst_ni, .clr_i(eof_i), .beat_i(beat), .whole_i(whole),
    .data_i, .crc_ok_o(crc_ok)
  );

  frm_verdict #(.LEN_MIN(LEN_MIN), .LEN_STD(LEN_STD), .LEN_TAG(LEN_TAG), .LEN_W(LEN_W)) u_verdict (
    .clk_i, .rst_ni, .eof_i, .len_i(len), .half_i(half), .dribble_i,
    .crc_ok_i(crc_ok), .vlan_i(vlan_q), .crc_off_i(crc_off_q),
    .good_o, .drop_o, .reason_o, .err_o
  );
endmodule

// File: rtl/frm_rx_check_sva.sv
`timescale 1ns/1ps
module frm_rx_check_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eof_i,
  input logic       good_o,
  input logic       drop_o,
  input logic [2:0] reason_o,
  input logic [3:0] err_o
);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(good_o && drop_o));
  p_eof_resp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> (good_o || drop_o));
  p_resp_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_o || drop_o) |-> $past(eof_i));
  p_good_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> (reason_o == 3'd0 && err_o == 4'd0));
  p_drop_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (reason_o >= 3'd1 && reason_o <= 3'd4 && err_o != 4'd0));
  p_runt_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && err_o[0]) |-> reason_o == 3'd1);
  p_align_rank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && err_o[2] && !err_o[0] && !err_o[1]) |-> reason_o == 3'd3);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(good_o || drop_o) |-> (reason_o == 3'd0 && err_o == 4'd0));
endmodule

bind frm_rx_check frm_rx_check_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .eof_i(eof_i),
  .good_o(good_o), .drop_o(drop_o), .reason_o(reason_o), .err_o(err_o)
);

// File: tb/sim_frm_rx_check.sv
`timescale 1ns/1ps
module sim_frm_rx_check;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] data_i = '0;
  logic       eof_i = 1'b0;
  logic       dribble_i = 1'b0;
  logic       vlan_strap_i = 1'b0;
  logic       crc_off_strap_i = 1'b0;
  logic       good_o, drop_o;
  logic [2:0] reason_o;
  logic [3:0] err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;
  logic [7:0] fb [0:2199];
  logic cur_vlan = 1'b0;
  logic cur_off = 1'b0;

  frm_rx_check u0 (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // n counts total bytes including FCS
  task automatic build(input int n, input logic corrupt);
    logic [31:0] f;
    for (int i = 0; i < n - 4; i++) fb[i] = 8'($urandom);
    f = ref_crc(n - 4);
    for (int i = 0; i < 4; i++) fb[n-4+i] = f[8*i +: 8];
    if (corrupt) fb[$urandom % (n - 4)] ^= 8'h10;
  endtask

  task automatic do_reset(input logic vlan, input logic off);
    @(negedge clk_i);
    rst_ni = 1'b0; vlan_strap_i = vlan; crc_off_strap_i = off;
    cur_vlan = vlan; cur_off = off;
    repeat (2) @(negedge clk_i);
    chk(!good_o && !drop_o && reason_o == 0 && err_o == 0, "R10 reset outputs", {good_o, drop_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    vlan_strap_i = ~vlan; crc_off_strap_i = ~off;  // later changes must be ignored (R6)
  endtask

  function automatic logic [2:0] exp_rsn(input int n, input logic odd, input logic bad, output logic [3:0] fl);
    int  l  = (n > 2047) ? 2047 : n;
    logic r = l < 64;
    logic g = l > (cur_vlan ? 1522 : 1518);
    logic a = odd & bad;
    logic c = ~odd & bad & ~cur_off;
    fl = {c, a, g, r};
    if (r) return 3'd1;
    if (g) return 3'd2;
    if (a) return 3'd3;
    if (c) return 3'd4;
    return 3'd0;
  endfunction

  task automatic send(input int n, input logic corrupt, input logic extra, input logic drib,
                      input logic gaps, input string tag);
    logic [2:0] er;
    logic [3:0] ef;
    build(n, corrupt);
    for (int i = 0; i < n; i++) begin
      for (int h = 0; h < 2; h++) begin
        if (gaps && ($urandom % 8 == 0)) begin
          @(negedge clk_i); valid_i = 1'b0;
        end
        @(negedge clk_i); valid_i = 1'b1; data_i = fb[i][4*h +: 4];
      end
    end
    if (extra) begin
      @(negedge clk_i); valid_i = 1'b1; data_i = 4'($urandom);
    end
    @(negedge clk_i);
    valid_i = 1'b0; eof_i = 1'b1; dribble_i = drib;
    er = exp_rsn(n, extra | drib, corrupt, ef);
    @(negedge clk_i);
    eof_i = 1'b0; dribble_i = 1'b0;
    chk(good_o == (er == 0) && drop_o == (er != 0), {tag, " strobe"}, {good_o, drop_o}, (er == 0) ? 2 : 1);
    chk(reason_o == er, {tag, " reason R9"}, reason_o, er);
    chk(err_o == ef, {tag, " flags R9"}, err_o, ef);
    @(negedge clk_i);
    chk(!good_o && !drop_o, "R8 single strobe", {good_o, drop_o}, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    do_reset(1'b0, 1'b0);
    // R1 length floor
    send(63, 0, 0, 0, 0, "R1 63B");
    send(64, 0, 0, 0, 0, "R1 64B");
    send(20, 1, 0, 0, 0, "R1 runt+crc");
    // R2 standard ceiling
    send(1518, 0, 0, 0, 0, "R2 1518B");
    send(1519, 0, 0, 0, 0, "R2 1519B");
    send(1530, 0, 1, 0, 0, "R2 long+align");
    // R4 bad CRC
    send(100, 1, 0, 0, 0, "R4 crc bad");
    // R5 alignment
    send(100, 0, 1, 0, 0, "R5 odd nibble good crc");
    send(100, 1, 1, 0, 0, "R5 odd nibble bad crc");
    send(100, 1, 0, 1, 0, "R5 dribble bad crc");
    send(100, 0, 0, 1, 0, "R5 dribble good crc");
    // R7 saturation
    send(2148, 0, 0, 0, 0, "R7 saturate");
    // R8 beat in the eof cycle is ignored
    build(64, 0);
    for (int i = 0; i < 64; i++)
      for (int h = 0; h < 2; h++) begin
        @(negedge clk_i); valid_i = 1'b1; data_i = fb[i][4*h +: 4];
      end
    @(negedge clk_i); valid_i = 1'b1; data_i = 4'hA; eof_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0; eof_i = 1'b0;
    chk(good_o && reason_o == 0, "R8 eof-cycle beat ignored", reason_o, 0);
    send(64, 0, 0, 0, 0, "R8 next frame clean");
    // R3 tagged ceiling
    do_reset(1'b1, 1'b0);
    send(1522, 0, 0, 0, 0, "R3 1522B");
    send(1523, 0, 0, 0, 0, "R3 1523B");
    // R6 + R4 bypass strap, strap pins toggled after capture
    do_reset(1'b0, 1'b1);
    send(200, 1, 0, 0, 0, "R6 R4 crc bypass");
    send(200, 1, 1, 0, 0, "R5 align despite bypass");
    send(1520, 0, 0, 0, 0, "R6 vlan pin ignored");
    // constrained random
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 22; k++) begin
      int n = 8 + ($urandom % 1523);
      send(n, ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, 1'b1, "R9 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule